// File: doc/BRIEF.md
# Tamper Pin Edge Qualifier

This block watches one raw tamper pin and turns a change of its level into a single-cycle pulse. It runs on the system clock. It also takes a slow debounce tick, a one-cycle enable that a shared clock divider produces and that every instance receives. A polarity select decides whether rising or falling changes are reported. A per-pin enable bit and two mode bits, which are global across pins, pick one of four qualification disciplines.

The four disciplines are:

- **Pass-through:** every synchronized change is reported.
- **Stability:** a new level is reported only once it has held for four ticks.
- **First-edge with blanking:** the first change is reported at once, and later changes are ignored until the pin has settled for four ticks.
- **Three-sample majority vote:** the pin is sampled on ticks and the reported level follows the majority.

At reset the block takes the present pin level as its reference, so it never reports a change that did not happen.

Top module: `tamper_edge_qualifier`

## Requirements
- R1: `edge_pulse` is high for exactly one clock per reported change. A change is reported only when its new level equals `pol_rise`, so 1 selects rising changes and 0 selects falling ones.
- R2: While `rst` is high the block loads the current `pin_raw` level as its reference and holds `edge_pulse` low. After reset, no pulse occurs while the pin keeps that level.
- R3: With `deb_en`=0, every change of the pin is reported. The pulse is visible after the third rising clock edge that samples the new level: two synchronizer stages, then the registered output.
- R4: In stability mode (`deb_en`=1, `maj_sel`=0, `async_sel`=0), a new level is reported only after the synchronized pin has stayed constant across four debounce ticks. Bounces shorter than that produce no pulse.
- R5: The stability tick count returns to zero whenever the synchronized pin differs from its value one clock earlier, and it stops at four.
- R6: In blanking mode (`deb_en`=1, `maj_sel`=0, `async_sel`=1), the first change is reported with the latency of R3. Every later change is ignored until the pin has stayed constant across four ticks.
- R7: When blanking ends and the settled level differs from the last reported level, that difference is reported on the following clock.
- R8: In vote mode (`deb_en`=1, `maj_sel`=1), the synchronized pin is sampled on each tick into a window of the three latest samples. The resolved level is 1 when at least two samples are 1. A change of the resolved level is reported.
- R9: When `deb_en`=1, `maj_sel`=1 overrides `async_sel`.
- R10: When `deb_en`=0, `maj_sel` and `async_sel` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| deb_tick | input | 1 | Shared one-cycle debounce tick enable |
| deb_en | input | 1 | Debounce enable for this pin |
| maj_sel | input | 1 | Global majority-vote mode select |
| async_sel | input | 1 | Global blanking (first-edge) mode select |
| pol_rise | input | 1 | 1 reports rising changes, 0 reports falling |
| pin_raw | input | 1 | Asynchronous tamper pin |
| edge_pulse | output | 1 | Registered one-cycle qualified edge pulse |

## Verification
Two events can meet in one clock in blanking mode. The end of the blanking window and a pending level difference land on neighbouring clocks: the pin goes away for three cycles, returns during the blank, and then settles. The bench judges whether the unreported return is flagged exactly one clock after blanking ends. Changes of mode while tick and bounce patterns overlap are also compared clock by clock against a behavioural model, which keeps its own pin history, tick count and sample window.

// File: rtl/tqd_pkg.sv
package tqd_pkg;

  typedef enum logic [1:0] {
    TQD_RAW    = 2'd0,
    TQD_STABLE = 2'd1,
    TQD_BLANK  = 2'd2,
    TQD_VOTE   = 2'd3
  } tqd_mode_e;

  // Vote outranks blanking, blanking outranks stability; disabled means raw.
  function automatic tqd_mode_e tqd_pick(input logic en, input logic maj,
                                         input logic asy);
    if (!en)      return TQD_RAW;
    else if (maj) return TQD_VOTE;
    else if (asy) return TQD_BLANK;
    else          return TQD_STABLE;
  endfunction

endpackage

// File: rtl/tqd_sync.sv
module tqd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic level_o
);

  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        chain[g] <= pin_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= pin_async;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign level_o = chain[STAGES-1];

endmodule

// File: rtl/tqd_stab.sv
module tqd_stab #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic lvl_i,
  input  logic init_i,
  output logic prev_o,
  output logic full_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic          prev_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= init_i;
      cnt_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      if (lvl_i != prev_q)           cnt_q <= '0;
      else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign prev_o = prev_q;
  assign full_o = (cnt_q == LIM);

  a_r5_restart: assert property (@(posedge clk) disable iff (rst)
    (lvl_i != prev_q) |=> (cnt_q == '0));

  a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM);

endmodule

// File: rtl/tqd_vote.sv
module tqd_vote #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic smp_i,
  input  logic init_i,
  output logic lvl_o
);

  localparam int HALF = DEPTH / 2;

  logic [DEPTH-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst)         win_q <= {DEPTH{init_i}};
    else if (tick_i) win_q <= {win_q[DEPTH-2:0], smp_i};
  end

  assign lvl_o = ($countones(win_q) > HALF);

  a_r8_shift: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> (win_q[0] == $past(smp_i)));

endmodule

// File: rtl/tamper_edge_qualifier.sv
module tamper_edge_qualifier
  import tqd_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_TICKS = 4,
  parameter int VOTE_DEPTH   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic deb_tick,
  input  logic deb_en,
  input  logic maj_sel,
  input  logic async_sel,
  input  logic pol_rise,
  input  logic pin_raw,
  output logic edge_pulse
);

  logic      lvl_s, prev_lvl, stab_full, vote_lvl;
  logic      ref_q, blank_q;
  logic      nxt_ref, nxt_blank, fire;
  tqd_mode_e mode;

  tqd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_async(pin_raw), .level_o(lvl_s)
  );

  tqd_stab #(.LIMIT(STABLE_TICKS)) u_stab (
    .clk(clk), .rst(rst), .tick_i(deb_tick), .lvl_i(lvl_s),
    .init_i(pin_raw), .prev_o(prev_lvl), .full_o(stab_full)
  );

  tqd_vote #(.DEPTH(VOTE_DEPTH)) u_vote (
    .clk(clk), .rst(rst), .tick_i(deb_tick), .smp_i(lvl_s),
    .init_i(pin_raw), .lvl_o(vote_lvl)
  );

  assign mode = tqd_pick(deb_en, maj_sel, async_sel);

  always_comb begin
    nxt_ref   = ref_q;
    nxt_blank = 1'b0;
    fire      = 1'b0;
    unique case (mode)
      TQD_RAW: begin
        if (lvl_s != ref_q) begin
          fire    = 1'b1;
          nxt_ref = lvl_s;
        end
      end
      TQD_STABLE: begin
        if (stab_full && prev_lvl != ref_q) begin
          fire    = 1'b1;
          nxt_ref = prev_lvl;
        end
      end
      TQD_BLANK: begin
        nxt_blank = blank_q;
        if (!blank_q) begin
          if (lvl_s != ref_q) begin
            fire      = 1'b1;
            nxt_ref   = lvl_s;
            nxt_blank = 1'b1;
          end
        end else if (stab_full) begin
          nxt_blank = 1'b0;
        end
      end
      TQD_VOTE: begin
        if (vote_lvl != ref_q) begin
          fire    = 1'b1;
          nxt_ref = vote_lvl;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q      <= pin_raw;
      blank_q    <= 1'b0;
      edge_pulse <= 1'b0;
    end else begin
      ref_q      <= nxt_ref;
      blank_q    <= nxt_blank;
      edge_pulse <= fire && (nxt_ref == pol_rise);
    end
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    edge_pulse |=> !edge_pulse);

  a_r1_polarity: assert property (@(posedge clk) disable iff (rst)
    edge_pulse |-> (ref_q == $past(pol_rise)));

  a_r6_blank_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == TQD_BLANK && blank_q) |=> !edge_pulse);

  a_r2_reset_quiet: assert property (@(posedge clk)
    rst |=> !edge_pulse);

endmodule

// File: tb/tamper_edge_qualifier_tb_top.sv
`timescale 1ns/1ps
module tamper_edge_qualifier_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic deb_tick = 1'b0;
  logic deb_en = 1'b0;
  logic maj_sel = 1'b0;
  logic async_sel = 1'b0;
  logic pol_rise = 1'b1;
  logic pin_raw = 1'b1;
  logic edge_pulse;

  always #2.5 clk = ~clk;

  tamper_edge_qualifier dut_i (
    .clk(clk), .rst(rst), .deb_tick(deb_tick), .deb_en(deb_en),
    .maj_sel(maj_sel), .async_sel(async_sel), .pol_rise(pol_rise),
    .pin_raw(pin_raw), .edge_pulse(edge_pulse)
  );

  int    total = 0;
  int    bad = 0;
  int    pulses = 0;
  int    cyc = 0;
  int    tdiv = 0;
  bit    done = 1'b0;
  string cur_req = "R2";

  // Shared tick: one cycle in four.
  always @(negedge clk) begin
    if (tdiv == 3) begin deb_tick = 1'b1; tdiv = 0; end
    else begin deb_tick = 1'b0; tdiv = tdiv + 1; end
  end

  // Behavioural reference: pin history, tick count, sample window.
  bit m_hist[$];
  bit m_win[$];
  int m_cnt;
  bit m_blank, m_ref, m_exp;

  always @(posedge clk) begin : model
    bit lv, pv, vote, fire, nref, nblank;
    int ones, ncnt;
    if (rst) begin
      m_hist = {pin_raw, pin_raw, pin_raw};
      m_win  = {pin_raw, pin_raw, pin_raw};
      m_cnt = 0; m_blank = 1'b0; m_ref = pin_raw; m_exp = 1'b0;
    end else begin
      lv = m_hist[m_hist.size()-2];
      pv = m_hist[m_hist.size()-3];
      ones = 0;
      foreach (m_win[i]) if (m_win[i]) ones++;
      vote = (ones >= 2);
      if (lv != pv) ncnt = 0;
      else if (deb_tick && m_cnt < 4) ncnt = m_cnt + 1;
      else ncnt = m_cnt;
      fire = 1'b0; nref = m_ref; nblank = 1'b0;
      if (!deb_en) begin
        if (lv != m_ref) begin fire = 1'b1; nref = lv; end
      end else if (maj_sel) begin
        if (vote != m_ref) begin fire = 1'b1; nref = vote; end
      end else if (async_sel) begin
        nblank = m_blank;
        if (!m_blank) begin
          if (lv != m_ref) begin fire = 1'b1; nref = lv; nblank = 1'b1; end
        end else if (m_cnt == 4) nblank = 1'b0;
      end else begin
        if (m_cnt == 4 && pv != m_ref) begin fire = 1'b1; nref = pv; end
      end
      m_exp = fire && (nref == pol_rise);
      m_ref = nref; m_blank = nblank; m_cnt = ncnt;
      if (deb_tick) begin void'(m_win.pop_front()); m_win.push_back(lv); end
      m_hist.push_back(pin_raw);
      if (m_hist.size() > 4) void'(m_hist.pop_front());
    end
  end

  // Clock-by-clock comparison, pulse tally and watchdog.
  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      total++;
      if (edge_pulse !== m_exp) begin
        bad++;
        $display("FAIL %s cycle %0d: edge_pulse=%0b expected=%0b",
                 cur_req, cyc, edge_pulse, m_exp);
      end
      if (edge_pulse) pulses++;
      if (cyc > 20000) begin
        bad++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input bit v, input int n);
    pin_raw = v;
    repeat (n) @(negedge clk);
  endtask

  // Drive a rising change and check the three-clock latency.
  task automatic rise_latency(input string req);
    int a1, a2, a3;
    pin_raw = 1'b1;
    @(negedge clk); a1 = edge_pulse;
    @(negedge clk); a2 = edge_pulse;
    @(negedge clk); a3 = edge_pulse;
    chk(req, a1, 0);
    chk(req, a2, 0);
    chk(req, a3, 1);
  endtask

  initial begin
    // R2: reset with pin high, then quiet
    repeat (4) @(negedge clk);
    chk("R2", edge_pulse, 0);
    rst = 1'b0;
    pulses = 0;
    hold(1'b1, 20);
    chk("R2", pulses, 0);

    // R3: pass-through, rising reported
    cur_req = "R3"; deb_en = 1'b0; pol_rise = 1'b1; pulses = 0;
    hold(1'b0, 6);
    rise_latency("R3");
    hold(1'b1, 5);
    hold(1'b0, 6);
    hold(1'b1, 8);
    chk("R3", pulses, 2);

    // R1: falling polarity
    cur_req = "R1"; pol_rise = 1'b0; pulses = 0;
    hold(1'b0, 6); hold(1'b1, 6); hold(1'b0, 6); hold(1'b1, 8);
    chk("R1", pulses, 2);

    // R4: stability mode rejects bounces
    cur_req = "R4"; deb_en = 1'b1; maj_sel = 1'b0; async_sel = 1'b0; pol_rise = 1'b1;
    hold(1'b1, 40);
    hold(1'b0, 40);
    pulses = 0;
    for (int i = 0; i < 4; i++) begin hold(1'b1, 3); hold(1'b0, 3); end
    chk("R4", pulses, 0);
    hold(1'b1, 40);
    chk("R4", pulses, 1);

    // R5: interrupted stable runs restart the count
    cur_req = "R5";
    hold(1'b0, 40);
    pulses = 0;
    hold(1'b1, 10); hold(1'b0, 2); hold(1'b1, 10); hold(1'b0, 40);
    chk("R5", pulses, 0);
    hold(1'b1, 40);
    chk("R4", pulses, 1);

    // R6: blanking mode, first edge immediate
    cur_req = "R6"; async_sel = 1'b1;
    hold(1'b0, 40);
    pulses = 0;
    rise_latency("R6");
    for (int i = 0; i < 3; i++) begin hold(1'b0, 2); hold(1'b1, 2); end
    hold(1'b1, 40);
    chk("R6", pulses, 1);

    // R7: level back before blank ends is reported afterwards
    cur_req = "R7"; pulses = 0;
    hold(1'b0, 3);
    hold(1'b1, 40);
    chk("R7", pulses, 1);

    // R8: majority vote filters a one-tick glitch
    cur_req = "R8"; maj_sel = 1'b1; async_sel = 1'b0; pol_rise = 1'b0;
    hold(1'b1, 20);
    pulses = 0;
    hold(1'b0, 4); hold(1'b1, 20);
    chk("R8", pulses, 0);
    hold(1'b0, 20);
    chk("R8", pulses, 1);

    // R9: vote outranks blanking
    cur_req = "R9"; async_sel = 1'b1; pol_rise = 1'b1; pulses = 0;
    hold(1'b1, 4); hold(1'b0, 20);
    chk("R9", pulses, 0);
    hold(1'b1, 20);
    chk("R9", pulses, 1);

    // R10: mode bits ignored when debounce disabled
    cur_req = "R10"; deb_en = 1'b0; pulses = 0;
    hold(1'b0, 4); hold(1'b1, 4); hold(1'b0, 10);
    chk("R10", pulses, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule